// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns four external interrupt lines into maskable interrupt requests. Each line passes through a two-flop synchroniser and then into a sample register. A 2-bit sense field for each line selects what counts as an event: the line held low, any change, a falling transition or a rising transition. A transition is a difference between two consecutive samples, so any pulse that lasts longer than one clock period is caught.

In the three transition modes, an event sets a sticky flag for that pin. Software clears the flag by writing a one to it, and a one-cycle acknowledge pulse for the pin also clears it. In low-level mode nothing is latched: the flag bit reads back as the live level condition, and it stays asserted for as long as the line is low.

A pin's request reaches its output only while its mask bit and the global enable are both set. All per-pin requests are ORed into one combined request. Software reaches the sense control, the mask and the flags through a small register port with synchronous writes and combinational reads. Before changing a sense field, software should mask the pin, clear its flag, and only then unmask it.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control, mask and flag registers read 0, `req_o` and `irq_o` are low, and the synchroniser and sample registers hold 1 (idle-high lines).
- R2: Address 0 holds the sense control, with pin n in bits 2n+1:2n (pin 3 in bits 7:6, pin 0 in bits 1:0). Address 1 holds the mask, with pin n in bit n; upper bits read 0. Address 2 holds the flags, with pin n in bit n. Address 3 reads 0.
- R3: Sense code 11 sets the pin's flag on a 0-to-1 difference between two consecutive samples. A 1-to-0 difference does not set it.
- R4: Sense code 10 sets the pin's flag on a 1-to-0 difference between two consecutive samples. A 0-to-1 difference does not set it.
- R5: Sense code 01 sets the flag on any difference between consecutive samples. A pulse two clock periods long is detected.
- R6: Sense code 00 latches nothing. The flag bit reads 1 exactly while the synchronised line is low, and writing one to it has no lasting effect.
- R7: Writing a one to a flag bit at address 2 clears that flag. Writing zero leaves it unchanged.
- R8: If an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A one-cycle pulse on `ack_i[n]` clears flag n.
- R10: `req_o[n]` equals flag n AND mask bit n AND `global_en_i`, and `irq_o` is the OR of `req_o`.
- R11: In a transition mode, the flag is visible after the third rising clock edge that follows a change of the line. In level mode, the live flag follows after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 4 | Asynchronous external interrupt lines |
| global_en_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-pin one-cycle flag acknowledge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| req_o | output | 4 | Per-pin masked interrupt request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A line change driven just after edge E0 reaches the sample register at E2. A transition flag is therefore due after E3 and a level flag after E2. The bench counts exactly those edges before it queues its expectation, and it also checks the cycle before each one to confirm the flag is still clear. Register writes, acknowledges and clears take effect at the single edge that consumes them, and `req_o`, `irq_o` and `reg_rdata` follow combinationally. Every expectation is therefore compared a fraction of a nanosecond after the inputs settle, well away from any edge. The set-beats-clear case lines the clear write up with E3 of a rising event, so both act on the same edge.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  // Event from two consecutive samples; low-level mode never latches.
  function automatic logic sense_event(sense_t mode, logic cur, logic prev);
    logic ev;
    case (mode)
      SENSE_ANY:  ev = cur ^ prev;
      SENSE_FALL: ev = prev & ~cur;
      SENSE_RISE: ev = cur & ~prev;
      default:    ev = 1'b0;
    endcase
    return ev;
  endfunction

  function automatic logic is_latching(sense_t mode);
    return mode != SENSE_LOW;
  endfunction

endpackage

// File: rtl/eis_pin_sync.sv
`timescale 1ns/1ps
module eis_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sample_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign sample_o = chain_q[STAGES-1];
  assign prev_o   = prev_q;
endmodule

// File: rtl/eis_sense_detect.sv
`timescale 1ns/1ps
module eis_sense_detect
  import ext_irq_pkg::*;
(
  input  sense_t mode_i,
  input  logic   cur_i,
  input  logic   prev_i,
  output logic   edge_evt_o,
  output logic   edge_mode_o,
  output logic   level_o
);
  always_comb begin
    edge_evt_o  = sense_event(mode_i, cur_i, prev_i);
    edge_mode_o = is_latching(mode_i);
    level_o     = ~cur_i;
  end
endmodule

// File: rtl/eis_flag_bank.sv
`timescale 1ns/1ps
module eis_flag_bank #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] edge_evt_i,
  input  logic [NUM_PINS-1:0] edge_mode_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flag_q
);
  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_flag
      logic nxt;
      // set dominates clear; level mode keeps the latch empty
      always_comb begin
        if (!edge_mode_i[i])   nxt = 1'b0;
        else if (edge_evt_i[i]) nxt = 1'b1;
        else if (clr_i[i])      nxt = 1'b0;
        else                    nxt = flag_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/eis_regfile.sv
`timescale 1ns/1ps
module eis_regfile
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  localparam int CTRL_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] flag_view_i,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic [NUM_PINS-1:0] flag_clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic hit_ctrl, hit_mask, hit_flag;

  always_comb begin
    hit_ctrl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
    hit_mask = wr_en_i && (addr_i == ADDR_W'(ADDR_MASK));
    hit_flag = wr_en_i && (addr_i == ADDR_W'(ADDR_FLAG));
    flag_clr_o = hit_flag ? wdata_i[NUM_PINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (hit_mask) mask_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))      rdata_o = DATA_W'(ctrl_q);
    else if (addr_i == ADDR_W'(ADDR_MASK)) rdata_o = DATA_W'(mask_q);
    else if (addr_i == ADDR_W'(ADDR_FLAG)) rdata_o = DATA_W'(flag_view_i);
  end
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  input  logic                global_en_i,
  input  logic [NUM_PINS-1:0] ack_i,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] req_o,
  output logic                irq_o
);
  localparam int CTRL_W = 2 * NUM_PINS;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] sample_w, prev_w;
  logic [NUM_PINS-1:0] edge_evt_w, edge_mode_w, level_w;
  logic [NUM_PINS-1:0] wr_clr_w, clr_w, flag_q, flag_view_w;

  eis_regfile #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .flag_view_i(flag_view_w), .ctrl_q(ctrl_q),
    .mask_q(mask_q), .flag_clr_o(wr_clr_w), .rdata_o(reg_rdata)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      sense_t mode_w;
      assign mode_w = sense_t'(ctrl_q[2*i +: 2]);

      eis_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(irq_pin_i[i]),
        .sample_o(sample_w[i]), .prev_o(prev_w[i])
      );

      eis_sense_detect u_det (
        .mode_i(mode_w), .cur_i(sample_w[i]), .prev_i(prev_w[i]),
        .edge_evt_o(edge_evt_w[i]), .edge_mode_o(edge_mode_w[i]),
        .level_o(level_w[i])
      );

      assign flag_view_w[i] = edge_mode_w[i] ? flag_q[i] : level_w[i];
    end
  endgenerate

  assign clr_w = wr_clr_w | ack_i;

  eis_flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .edge_evt_i(edge_evt_w),
    .edge_mode_i(edge_mode_w), .clr_i(clr_w), .flag_q(flag_q)
  );

  assign req_o = flag_view_w & mask_q & {NUM_PINS{global_en_i}};
  assign irq_o = |req_o;
endmodule

// File: rtl/ext_irq_sense_chk.sv
`timescale 1ns/1ps
module ext_irq_sense_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] edge_evt,
  input logic [NUM_PINS-1:0] edge_mode,
  input logic [NUM_PINS-1:0] clr,
  input logic [NUM_PINS-1:0] ack,
  input logic [NUM_PINS-1:0] flag_q
);
  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_chk
      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt[i] && edge_mode[i]) |=> flag_q[i]);
      // R9
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[i] && !edge_evt[i]) |=> !flag_q[i]);
      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !edge_evt[i] && edge_mode[i]) |=> $stable(flag_q[i]));
      // R3
      flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(edge_evt[i]));
      // R6
      level_unlatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode[i] |=> !flag_q[i]);
    end
  endgenerate
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt_w), .edge_mode(edge_mode_w),
  .clr(clr_w), .ack(ack_i), .flag_q(flag_q)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_pin_i = 4'hF;
  logic       global_en_i = 1'b0;
  logic [3:0] ack_i = 4'h0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] req_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [3:0] req;
    logic       irq;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin_i), .global_en_i(global_en_i),
    .ack_i(ack_i), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_o(req_o), .irq_o(irq_o)
  );

  // monitor: pops each expectation and compares after inputs settle
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() > 0);
      #0.2;
      e = sb_q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || req_o !== e.req || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: actual rd=%h req=%b irq=%b expected rd=%h req=%b irq=%b",
                 e.tag, reg_rdata, req_o, irq_o, e.rd, e.req, e.irq);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_state(string tag, logic [1:0] addr, logic [7:0] rd,
                              logic [3:0] req, logic irq);
    exp_t e;
    reg_addr = addr;
    e.tag = tag; e.rd = rd; e.req = req; e.irq = irq;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic reg_write(logic [1:0] addr, logic [7:0] data);
    reg_addr = addr; reg_wdata = data; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_state("R1 ctrl", 2'd0, 8'h00, 4'h0, 1'b0);
    expect_state("R1 mask", 2'd1, 8'h00, 4'h0, 1'b0);
    expect_state("R1 flags", 2'd2, 8'h00, 4'h0, 1'b0);

    // R2 map: pin3=00 low, pin2=01 any, pin1=10 fall, pin0=11 rise
    reg_write(2'd0, 8'h1B);
    expect_state("R2 ctrl readback", 2'd0, 8'h1B, 4'h0, 1'b0);
    reg_write(2'd1, 8'hFF);
    expect_state("R2 mask upper bits zero", 2'd1, 8'h0F, 4'h0, 1'b0);
    reg_write(2'd1, 8'h00);
    expect_state("R2 addr3 reads zero", 2'd3, 8'h00, 4'h0, 1'b0);
    expect_state("R2 flags idle", 2'd2, 8'h00, 4'h0, 1'b0);

    // R3 rising mode ignores fall
    irq_pin_i[0] = 1'b0;
    step(4);
    expect_state("R3 fall ignored", 2'd2, 8'h00, 4'h0, 1'b0);
    irq_pin_i[0] = 1'b1;
    step(2);
    expect_state("R11 not yet after 2 edges", 2'd2, 8'h00, 4'h0, 1'b0);
    step();
    expect_state("R3 R11 rise flagged at edge 3", 2'd2, 8'h01, 4'h0, 1'b0);

    // R10 gating
    reg_write(2'd1, 8'h01);
    expect_state("R10 global off", 2'd2, 8'h01, 4'h0, 1'b0);
    global_en_i = 1'b1;
    expect_state("R10 mask and global", 2'd2, 8'h01, 4'h1, 1'b1);

    // R7 write-one-to-clear
    reg_write(2'd2, 8'h00);
    expect_state("R7 write zero keeps", 2'd2, 8'h01, 4'h1, 1'b1);
    reg_write(2'd2, 8'h01);
    expect_state("R7 write one clears", 2'd2, 8'h00, 4'h0, 1'b0);

    // R4 falling mode
    irq_pin_i[1] = 1'b0;
    step(3);
    expect_state("R4 fall flagged", 2'd2, 8'h02, 4'h0, 1'b0);
    reg_write(2'd2, 8'h02);
    irq_pin_i[1] = 1'b1;
    step(4);
    expect_state("R4 rise ignored", 2'd2, 8'h00, 4'h0, 1'b0);

    // R5 any change, two-cycle pulse
    irq_pin_i[2] = 1'b0;
    step(2);
    irq_pin_i[2] = 1'b1;
    step(4);
    expect_state("R5 short pulse flagged", 2'd2, 8'h04, 4'h0, 1'b0);
    reg_write(2'd2, 8'h04);
    expect_state("R5 cleared", 2'd2, 8'h00, 4'h0, 1'b0);

    // R6 low level, live
    reg_write(2'd1, 8'h08);
    irq_pin_i[3] = 1'b0;
    step();
    expect_state("R11 level not yet after 1 edge", 2'd2, 8'h00, 4'h0, 1'b0);
    step();
    expect_state("R6 R11 level live after 2 edges", 2'd2, 8'h08, 4'h8, 1'b1);
    reg_write(2'd2, 8'h08);
    expect_state("R6 clear has no effect while low", 2'd2, 8'h08, 4'h8, 1'b1);
    irq_pin_i[3] = 1'b1;
    step(2);
    expect_state("R6 release drops request", 2'd2, 8'h00, 4'h0, 1'b0);

    // R8 set beats clear on the same edge
    irq_pin_i[0] = 1'b0;
    step(4);
    irq_pin_i[0] = 1'b1;
    step(2);
    reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
    expect_state("R8 set wins", 2'd2, 8'h01, 4'h0, 1'b0);

    // R9 acknowledge
    ack_i = 4'h1;
    step();
    ack_i = 4'h0;
    expect_state("R9 ack clears", 2'd2, 8'h00, 4'h0, 1'b0);

    // R10 global disable keeps flag
    irq_pin_i[0] = 1'b0;
    step(4);
    irq_pin_i[0] = 1'b1;
    step(3);
    reg_write(2'd1, 8'h01);
    expect_state("R10 request on", 2'd2, 8'h01, 4'h1, 1'b1);
    global_en_i = 1'b0;
    expect_state("R10 global off blocks", 2'd2, 8'h01, 4'h0, 1'b0);

    done = 1'b1;
    report();
  end
endmodule